// File: doc/BRIEF.md
# Manchester Line Encoder with Selectable Idle

This block turns a serial NRZ transmit stream into a Manchester-coded signal on a complementary pair of logic outputs, `tx_p` and `tx_n`. It runs from a clock at twice the bit rate, so each bit cell spans two clock cycles (two half-cells). A frame opens on the first rising clock edge at which `tx_en` is seen high. It goes on cell after cell while `tx_en` stays high at each cell boundary, and it closes at the first boundary where `tx_en` is low.

Between frames the pair rests in an idle condition picked by `idle_bal`. With `idle_bal` low the rest state is offset: `tx_p` high and `tx_n` low. With `idle_bal` high the rest state is balanced, with both outputs low. The outputs are decoded from three state flops and the mode input, so in idle a change of `idle_bal` reaches the pair at once. Analog levels and line coupling lie outside this block.

Top module: `manchester_tx`

## Requirements
- R1: While `rst_n` is low, and after the first rising edge that samples it low, the frame state is cleared and the outputs show the idle state for the current `idle_bal`.
- R2: In idle with `idle_bal` low, the outputs are `tx_p`=1, `tx_n`=0.
- R3: In idle with `idle_bal` high, the outputs are `tx_p`=0, `tx_n`=0. The two outputs are never both high.
- R4: From idle, the first rising edge that samples `tx_en`=1 starts a bit cell. The first half-cell of that bit appears right after that edge, and `tx_data` is captured at the same edge.
- R5: A bit 0 is sent as `tx_p` high then low, and a bit 1 as `tx_p` low then high. While a frame is active, `tx_n` is the complement of `tx_p`, so every cell has a transition at its centre.
- R6: `tx_data` is sampled only at the edge that opens a cell. A change during the second half-cell has no effect on the line.
- R7: `tx_en` is sampled only at the edge that opens a cell. Dropping it at the mid-cell edge still lets the current cell finish both halves.
- R8: If `tx_en` is low at the edge ending a cell, the frame ends and idle begins at that edge. In offset mode, a last bit of 1 makes the final transition fall at the cell centre, because the boundary shows no change. A last bit of 0 makes the final transition fall at the boundary.
- R9: If `tx_en` is high at the edge ending a cell, the next bit starts at that same edge with no idle half-cell in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock at twice the bit rate, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Frame enable, sampled at cell boundaries |
| tx_data | input | 1 | NRZ bit, sampled when a cell opens |
| idle_bal | input | 1 | Idle mode: 0 offset (p=1, n=0), 1 balanced (p=0, n=0) |
| tx_p | output | 1 | Positive line output |
| tx_n | output | 1 | Negative line output |

## Verification
The assertions assume that `tx_en` and `tx_data` are stable around each rising clock edge, and that `rst_n` changes only away from the edge. The bench drives every input on the falling edge and samples the outputs one nanosecond after the rising edge, so each input value settles well inside the sampling window. The checks on the mid-cell transition and on cell completion only look at cycles after reset has been released, so the values held before the first edge play no part. `idle_bal` is changed only while the encoder is idle. A mode switch inside a frame therefore never reaches the checks that depend on the idle state.

// File: rtl/manchester_tx.sv
module manchester_tx (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_data,
  input  logic idle_bal,
  output logic tx_p,
  output logic tx_n
);

  logic act_q;
  logic half_q;
  logic bit_q;

  logic cell_end;
  logic open_cell;

  assign cell_end  = act_q & half_q;
  assign open_cell = tx_en & (~act_q | half_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= 1'b0;
    end else if (open_cell) begin
      act_q  <= 1'b1;
      half_q <= 1'b0;
      bit_q  <= tx_data;
    end else if (cell_end) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (act_q) begin
      half_q <= 1'b1;
    end
  end

  logic line_p;
  assign line_p = half_q ? bit_q : ~bit_q;

  assign tx_p = act_q ? line_p  : ~idle_bal;
  assign tx_n = act_q ? ~line_p : 1'b0;

endmodule

module manchester_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_p,
  input logic tx_n,
  input logic act,
  input logic half,
  input logic bit_v
);

  assert_never_both_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_p && tx_n));

  assert_start_on_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && tx_en) |=> (act && !half));

  assert_mid_cell_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !half) |=> (tx_p != $past(tx_p)) && (tx_n != tx_p));

  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !half) |=> $stable(bit_v));

  assert_cell_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !half) |=> (act && half));

  assert_stop_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act && half && !tx_en) |=> !act);

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && half && tx_en) |=> (act && !half));

endmodule

bind manchester_tx manchester_tx_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tx_en (tx_en),
  .tx_p  (tx_p),
  .tx_n  (tx_n),
  .act   (act_q),
  .half  (half_q),
  .bit_v (bit_q)
);

// File: tb/test_manchester_tx.sv
module test_manchester_tx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic tx_data = 1'b0;
  logic idle_bal = 1'b0;
  logic tx_p;
  logic tx_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  manchester_tx i_manchester_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tx_data  (tx_data),
    .idle_bal (idle_bal),
    .tx_p     (tx_p),
    .tx_n     (tx_n)
  );

  // {en, data, mode, exp_p, exp_n}, one entry per clock
  localparam logic [4:0] VEC [20] = '{
    5'b00010, // idle offset R2
    5'b10010, // start bit 0, first half R4
    5'b11001, // second half, data change ignored R6
    5'b11001, // bit 1 first half R9
    5'b00010, // en drops mid-cell, cell completes R7
    5'b10010, // bit 0 first half
    5'b11001, // bit 0 second half
    5'b01010, // end after 0: change at boundary R8
    5'b00010, // idle
    5'b11001, // bit 1 first half
    5'b00010, // bit 1 second half
    5'b00010, // end after 1: no change at boundary R8
    5'b00100, // balanced idle R3
    5'b11101, // bit 1 first half
    5'b10110, // bit 1 second half
    5'b00100, // end, balanced idle R3
    5'b10110, // bit 0 first half
    5'b00101, // bit 0 second half
    5'b01100, // end R8
    5'b00010  // back to offset idle R2
  };

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got p,n=%b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic en, input logic d, input logic m);
    @(negedge clk);
    tx_en = en;
    tx_data = d;
    idle_bal = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pattern;
    // R1: reset state in both modes
    step(1'b1, 1'b1, 1'b0);
    check("R1", {tx_p, tx_n}, 2'b10);
    step(1'b1, 1'b0, 1'b1);
    check("R1", {tx_p, tx_n}, 2'b00);
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      check("R2-R9 vector", {tx_p, tx_n}, VEC[i][1:0]);
    end

    // R5 / R9: continuous stream, checked per half-cell
    pattern = 8'b10110010;
    for (int b = 7; b >= 0; b--) begin
      step(1'b1, pattern[b], 1'b0);
      check("R5", {tx_p, tx_n}, {~pattern[b], pattern[b]});
      step(1'b1, ~pattern[b], 1'b0);
      check("R5", {tx_p, tx_n}, {pattern[b], ~pattern[b]});
    end
    step(1'b0, 1'b0, 1'b0);
    check("R8", {tx_p, tx_n}, 2'b10);

    // R1: reset in the middle of a frame returns to idle
    step(1'b1, 1'b1, 1'b0);
    check("R4", {tx_p, tx_n}, 2'b01);
    @(negedge clk);
    rst_n = 1'b0;
    tx_en = 1'b0;
    @(posedge clk);
    #1;
    check("R1", {tx_p, tx_n}, 2'b10);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: data toggling in the second half leaves the bit unchanged
    step(1'b1, 1'b0, 1'b1);
    check("R6", {tx_p, tx_n}, 2'b10);
    step(1'b0, 1'b1, 1'b1);
    check("R6", {tx_p, tx_n}, 2'b01);
    step(1'b0, 1'b1, 1'b1);
    check("R3", {tx_p, tx_n}, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule